// File: doc/BRIEF.md
# Capture Word Ring with Newest-Pair Lane Unpacker

This block takes an endless stream of 32-bit capture words and stores them in a circular buffer whose depth is a power of two. The write pointer wraps by itself, so writing never needs to be restarted from outside. Each conversion result fills two consecutive words, and the first word of a pair always sits at an even slot.

When a consumer raises a read request, the block picks the newest complete pair that is safely behind the write pointer. It copies both words in two back-to-back cycles and separates the bits into three lane samples. Each nibble of the pair holds one bit for each lane. A done strobe marks the cycle in which the lane outputs are valid. A request made before any complete pair exists finishes with the done strobe and a cleared valid flag.

The read controller is a state machine with four states. RD_IDLE waits for a request. The transition take_pair goes to RD_GRAB_LO when a complete pair exists. The transition no_pair stays in RD_IDLE and reports not-valid. RD_GRAB_LO copies the even word and moves on through grab_next to RD_GRAB_HI. RD_GRAB_HI copies the odd word and moves on through grab_done to RD_UNPACK. RD_UNPACK registers the lane values and returns through publish to RD_IDLE.

Top module: `sample_ring_reader`

## Requirements
- R1: After reset, wr_index is 0, and rd_done, rd_valid and all three lane outputs are 0.
- R2: Every cycle with in_valid high stores in_word at slot wr_index, and wr_index then advances by one. With in_valid low, wr_index holds its value. in_ready is always high.
- R3: After a write to slot DEPTH-1 (63 by default), wr_index becomes 0 and writing carries on with no other input.
- R4: A request accepted before slot 1 has ever been written gives rd_done high with rd_valid low in the cycle after the request. The lane outputs keep their previous values.
- R5: Let wr_index be W at the clock edge that accepts the request. If W is 0 or 1, the pair read is at slots DEPTH-2 and DEPTH-1. Otherwise the first slot is W rounded down to even, minus 2, and the second slot is the one after it.
- R6: The first word supplies its bits 15..0 and the second word supplies its bits 31..0. Together they form 12 nibbles, taken from the most significant nibble down to the least significant nibble. Nibble bit 0 goes to lane_a, bit 1 to lane_b and bit 2 to lane_c. Bit 3 is dropped. The first nibble becomes lane bit 11, and lane bits 15..12 are 0.
- R7: For a request accepted while a pair exists, rd_done and rd_valid go high exactly four cycles after the accepting edge, for one cycle only. The lane outputs then hold until the next completed read.
- R8: A request raised while a read is still in progress is ignored and produces no done strobe.
- R9: Words written while a read is in progress do not change the result. The result is the pair that was stored at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture word present |
| in_ready | output | 1 | Always high; the ring never stalls |
| in_word | input | 32 | Capture word |
| wr_index | output | 6 | Slot that the next word will be written to |
| rd_req | input | 1 | Read request strobe |
| rd_done | output | 1 | One-cycle strobe marking a finished read |
| rd_valid | output | 1 | High at rd_done if a pair was available |
| lane_a | output | 16 | Lane A sample |
| lane_b | output | 16 | Lane B sample |
| lane_c | output | 16 | Lane C sample |

## Verification
The bench targets the boundaries of pair selection: write indices 0 and 1, where the read must come from the top of the ring, and both odd and even indices in the middle. A design with an off-by-one here would return a half-written pair or the pair before the newest one. Nibble patterns that use only bit 3 confirm that the dropped bit never reaches a lane, and a reversed order would show up as mirrored lane values. The bench also writes words during a read and sends requests while the controller is busy. A design that tears the pair, or starts a second read, would produce wrong lane values or an extra done strobe. Requests made before the first pair is complete must report not-valid and leave the lane outputs unchanged.

// File: rtl/ring_pkg.sv
package ring_pkg;
    typedef enum logic [1:0] {
        RD_IDLE,
        RD_GRAB_LO,
        RD_GRAB_HI,
        RD_UNPACK
    } rd_state_t;
endpackage

// File: rtl/ring_store.sv
module ring_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [AW-1:0]     wr_idx,
    output logic              have_pair,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] slots [DEPTH];

    initial begin
        if (DEPTH != (1 << AW) || DEPTH < 4) $error("depth must be a power of two >= 4");
    end

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx    <= '0;
            have_pair <= 1'b0;
        end else if (wr_en) begin
            wr_idx <= wr_idx + AW'(1);
            if (wr_idx == AW'(1)) have_pair <= 1'b1;
        end
    end

    assign rd_word = slots[rd_addr];

    // R2
    wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_idx == $past(wr_idx) + AW'(1));
    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(wr_idx));
    // R3
    wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == AW'(DEPTH - 1)) |=> wr_idx == '0);
endmodule

// File: rtl/pair_pick.sv
module pair_pick #(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic [AW-1:0] wr_idx,
    output logic [AW-1:0] base
);
    always_comb begin
        if (wr_idx <= AW'(1)) base = AW'(DEPTH - 2);
        else                  base = {wr_idx[AW-1:1], 1'b0} - AW'(2);
    end
endmodule

// File: rtl/lane_unpack.sv
module lane_unpack #(
    parameter int WORD_W = 32,
    parameter int LANE_W = 16,
    localparam int HALF     = WORD_W / 2,
    localparam int STREAM_W = HALF + WORD_W,
    localparam int NIBS     = STREAM_W / 4
) (
    input  logic [WORD_W-1:0] first_word,
    input  logic [WORD_W-1:0] second_word,
    output logic [LANE_W-1:0] lane_a,
    output logic [LANE_W-1:0] lane_b,
    output logic [LANE_W-1:0] lane_c
);
    logic [STREAM_W-1:0] stream;
    logic [NIBS-1:0]     bits_a, bits_b, bits_c;

    assign stream = {first_word[HALF-1:0], second_word};

    for (genvar k = 0; k < NIBS; k++) begin : g_nib
        localparam int LOWBIT = STREAM_W - 4 - 4 * k;
        assign bits_a[NIBS-1-k] = stream[LOWBIT];
        assign bits_b[NIBS-1-k] = stream[LOWBIT + 1];
        assign bits_c[NIBS-1-k] = stream[LOWBIT + 2];
    end

    assign lane_a = LANE_W'(bits_a);
    assign lane_b = LANE_W'(bits_b);
    assign lane_c = LANE_W'(bits_c);
endmodule

// File: rtl/read_ctrl.sv
module read_ctrl
    import ring_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    parameter int LANE_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              have_pair,
    input  logic [AW-1:0]     base_in,
    input  logic [AW-1:0]     wr_idx,
    output logic [AW-1:0]     rd_addr,
    input  logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] first_q,
    output logic [WORD_W-1:0] second_q,
    input  logic [LANE_W-1:0] unp_a,
    input  logic [LANE_W-1:0] unp_b,
    input  logic [LANE_W-1:0] unp_c,
    output logic              rd_done,
    output logic              rd_valid,
    output logic [LANE_W-1:0] lane_a,
    output logic [LANE_W-1:0] lane_b,
    output logic [LANE_W-1:0] lane_c
);
    rd_state_t state, state_nx;
    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE:    if (rd_req && have_pair) state_nx = RD_GRAB_LO;
            RD_GRAB_LO: state_nx = RD_GRAB_HI;
            RD_GRAB_HI: state_nx = RD_UNPACK;
            RD_UNPACK:  state_nx = RD_IDLE;
            default:    state_nx = RD_IDLE;
        endcase
    end

    assign rd_addr = (state == RD_GRAB_HI) ? (base_q | AW'(1)) : base_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            first_q  <= '0;
            second_q <= '0;
            rd_done  <= 1'b0;
            rd_valid <= 1'b0;
            lane_a   <= '0;
            lane_b   <= '0;
            lane_c   <= '0;
        end else begin
            rd_done  <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state)
                RD_IDLE: begin
                    if (rd_req) begin
                        base_q <= base_in;
                        if (!have_pair) rd_done <= 1'b1;
                    end
                end
                RD_GRAB_LO: first_q  <= rd_word;
                RD_GRAB_HI: second_q <= rd_word;
                RD_UNPACK: begin
                    lane_a   <= unp_a;
                    lane_b   <= unp_b;
                    lane_c   <= unp_c;
                    rd_done  <= 1'b1;
                    rd_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R4
    no_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_IDLE && rd_req && !have_pair) |=> (rd_done && !rd_valid && $stable(lane_a)));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && rd_valid) |=> !rd_done);
    // R7
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_IDLE && rd_req && have_pair) |=> state == RD_GRAB_LO);
    // R8
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RD_IDLE) |=> !(rd_done && !rd_valid));
    // R5
    safe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_GRAB_LO) |-> (base_q != wr_idx && (base_q | AW'(1)) != wr_idx));
endmodule

// File: rtl/sample_ring_reader.sv
module sample_ring_reader #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    parameter int LANE_W = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic [AW-1:0]     wr_index,
    input  logic              rd_req,
    output logic              rd_done,
    output logic              rd_valid,
    output logic [LANE_W-1:0] lane_a,
    output logic [LANE_W-1:0] lane_b,
    output logic [LANE_W-1:0] lane_c
);
    logic              have_pair;
    logic [AW-1:0]     base, rd_addr;
    logic [WORD_W-1:0] rd_word, first_q, second_q;
    logic [LANE_W-1:0] unp_a, unp_b, unp_c;

    assign in_ready = 1'b1;

    ring_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_en(in_valid), .wr_data(in_word),
        .wr_idx(wr_index), .have_pair(have_pair), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    pair_pick #(.DEPTH(DEPTH)) pick_i (.wr_idx(wr_index), .base(base));

    lane_unpack #(.WORD_W(WORD_W), .LANE_W(LANE_W)) unpack_i (
        .first_word(first_q), .second_word(second_q),
        .lane_a(unp_a), .lane_b(unp_b), .lane_c(unp_c)
    );

    read_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LANE_W(LANE_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .have_pair(have_pair),
        .base_in(base), .wr_idx(wr_index), .rd_addr(rd_addr), .rd_word(rd_word),
        .first_q(first_q), .second_q(second_q),
        .unp_a(unp_a), .unp_b(unp_b), .unp_c(unp_c),
        .rd_done(rd_done), .rd_valid(rd_valid),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c)
    );
endmodule

// File: tb/sample_ring_reader_tb.sv
module sample_ring_reader_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [31:0] in_word = '0;
    logic [AW-1:0] wr_index;
    logic rd_req = 1'b0;
    logic rd_done, rd_valid;
    logic [15:0] lane_a, lane_b, lane_c;

    sample_ring_reader dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .wr_index(wr_index), .rd_req(rd_req),
        .rd_done(rd_done), .rd_valid(rd_valid),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [31:0] model [DEPTH];
    int model_idx = 0;
    bit model_pair = 0;
    int busy_until = 0;
    logic [15:0] last_a = '0, last_b = '0, last_c = '0;
    logic [48:0] exp_q [$];
    int exp_cyc_q [$];
    string exp_tag_q [$];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [47:0] unpack_ref(input logic [31:0] w0, input logic [31:0] w1);
        logic [15:0] a = '0, b = '0, c = '0;
        logic [47:0] s = {w0[15:0], w1};
        for (int n = 0; n < 12; n++) begin
            logic [3:0] g = s[47 - 4 * n -: 4];
            a = {a[14:0], g[0]};
            b = {b[14:0], g[1]};
            c = {c[14:0], g[2]};
        end
        return {a, b, c};
    endfunction

    task automatic step(input bit v, input logic [31:0] d, input bit r, input string tag);
        @(negedge clk);
        in_valid = v;
        in_word  = d;
        rd_req   = r;
        if (r && cyc >= busy_until) begin
            if (!model_pair) begin
                exp_q.push_back({1'b0, last_a, last_b, last_c});
                exp_cyc_q.push_back(cyc + 1);
                busy_until = cyc + 1;
            end else begin
                int b0;
                logic [47:0] l;
                b0 = (model_idx <= 1) ? DEPTH - 2 : (model_idx / 2) * 2 - 2;
                l = unpack_ref(model[b0], model[b0 + 1]);
                {last_a, last_b, last_c} = l;
                exp_q.push_back({1'b1, l});
                exp_cyc_q.push_back(cyc + 4);
                busy_until = cyc + 4;
            end
            exp_tag_q.push_back(tag);
        end
        if (v) begin
            model[model_idx] = d;
            if (model_idx == 1) model_pair = 1;
            model_idx = (model_idx + 1) % DEPTH;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, '0, 0, "");
    endtask

    task automatic check_idx(input string tag);
        step(0, '0, 0, "");
        check(wr_index == AW'(model_idx), tag, "wr_index", 64'(wr_index), 64'(model_idx));
    endtask

    function automatic logic [31:0] gen(input int n);
        return (32'(n) * 32'h9E37_79B9) ^ 32'h5A3C_96E1;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_done) begin
            if (exp_q.size() == 0) begin
                check(0, "R8", "unexpected done", 64'(cyc), 64'(0));
            end else begin
                logic [48:0] e;
                int ec;
                string t;
                e  = exp_q.pop_front();
                ec = exp_cyc_q.pop_front();
                t  = exp_tag_q.pop_front();
                check({rd_valid, lane_a, lane_b, lane_c} == e, t, "valid+lanes",
                      64'({rd_valid, lane_a, lane_b, lane_c}), 64'(e));
                check(cyc == ec, "R7", "done cycle", 64'(cyc), 64'(ec));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(wr_index == '0, "R1", "wr_index", 64'(wr_index), 0);
        check(rd_done == 1'b0, "R1", "rd_done", 64'(rd_done), 0);
        check(rd_valid == 1'b0, "R1", "rd_valid", 64'(rd_valid), 0);
        check({lane_a, lane_b, lane_c} == '0, "R1", "lanes", 64'({lane_a, lane_b, lane_c}), 0);
        check(in_ready == 1'b1, "R2", "in_ready", 64'(in_ready), 1);
        rst_n = 1'b1;

        // R4 requests before any complete pair
        step(0, '0, 1, "R4");
        idle(3);
        step(1, 32'hABCD_1111, 0, "");
        step(0, '0, 1, "R4");
        idle(3);
        check_idx("R2");
        idle(3);
        check_idx("R2");

        // R6 first pair: lane a all ones
        step(1, 32'h1111_1111, 0, "");
        step(0, '0, 1, "R6");
        idle(6);
        // R6 only bit 3 set: all lanes zero
        step(1, 32'hFFFF_8888, 0, "");
        step(1, 32'h8888_8888, 0, "");
        step(0, '0, 1, "R6");
        idle(6);
        // R5 odd index 7 -> pair at 4,5
        step(1, 32'h0000_7654, 0, "");
        step(1, 32'h3210_FEDC, 0, "");
        step(1, 32'h4444_4444, 0, "");
        step(0, '0, 1, "R5");
        idle(6);
        // fill to slot 62, request at index 63
        for (int i = 7; i < 63; i++) step(1, gen(i), 0, "");
        step(0, '0, 1, "R5");
        idle(6);
        step(1, gen(63), 0, "");
        check_idx("R3");
        step(0, '0, 1, "R3");
        idle(6);
        step(1, 32'h2222_2222, 0, "");
        step(0, '0, 1, "R5");
        idle(6);

        // R9 writes during the read, R8 requests while busy
        for (int i = 0; i < 10; i++)
            step(1, gen(100 + i), (i >= 2 && i <= 5), (i == 2) ? "R9" : "R8");
        idle(8);
        check_idx("R2");
        check(exp_q.size() == 0, "R7", "pending results", 64'(exp_q.size()), 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule